// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block works out the operand address and the following program counter for an 8-bit processor with a 16-bit address space. A caller presents a mode, the 8-bit index value and the program counter that points at the opcode, then pulses `start`. The block fetches the operand bytes that follow the opcode through a byte-wide read port, one byte per clock, and then raises `done` for one cycle. In that cycle `effAddr` holds the operand address and `pcNext` holds the advanced program counter.

Four address forms are built. The direct-absolute form takes a full 16-bit address from two operand bytes. The three indexed forms add the unsigned index to nothing, to one fetched byte, or to a fetched 16-bit base. The adder always settles the low byte first and feeds its carry into the high byte. The read port is asynchronous: `rdData` must reflect `rdAddr` in the same cycle, and the block samples it at the closing clock edge.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode 0 (absolute): the byte at PC+1 becomes the high address byte and the byte at PC+2 the low byte. `pcNext` is PC+3, and `done` rises three cycles after the start cycle.
- R2: Mode 1 (index only): `effAddr` is {0x00, index}, `pcNext` is PC+1, and no read is issued (`rdEn` stays low). `done` rises in the cycle after start.
- R3: Mode 2 (index plus byte): the low byte is index + byte[PC+1], and the high byte is only the carry of that sum, so the result never exceeds 0x01FE. `pcNext` is PC+2, and `done` rises two cycles after start.
- R4: Mode 3 (index plus word): the low byte is index + byte[PC+2], and the high byte is byte[PC+1] plus that carry, taken modulo 256. An address that passes 0xFFFF wraps to the bottom of memory. `pcNext` is PC+3, and `done` rises three cycles after start.
- R5: The index and every offset byte are unsigned. Values of 0x80 and above add without sign extension.
- R6: Operand reads go out with `rdEn` high in consecutive cycles, PC+1 first and PC+2 second. Read addresses and `pcNext` wrap modulo 2^16.
- R7: `done` is high for exactly one cycle per accepted operation. A `start` that arrives while an operation is in progress is ignored.
- R8: Synchronous reset clears `done`, `rdEn`, `effAddr` and `pcNext` to zero.
- R9: Mode values 4 to 7 are a no-op. `done` rises in the cycle after start with `pcNext` equal to PC and `effAddr` equal to 0, and no read is issued.
- R10: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 3 | Address form: 0 absolute, 1 index only, 2 index+byte, 3 index+word, 4-7 no-op |
| indexReg | input | 8 | Unsigned index value |
| pcIn | input | 16 | Program counter pointing at the opcode |
| rdEn | output | 1 | High when an operand byte is being read |
| rdAddr | output | 16 | Operand read address |
| rdData | input | 8 | Byte at `rdAddr`, valid in the same cycle |
| effAddr | output | 16 | Effective operand address, valid while `done` is high |
| pcNext | output | 16 | Advanced program counter, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle, because the controller returns to idle on the edge that raises `done`. To provoke this, the bench watches for `done` while an index-plus-byte operation runs and drives a new index-only `start` in that same cycle. It judges the result on two counts: the first result must be correct in that cycle, and `done` must be high again in the very next cycle carrying the second result. A separate test sends `start` mid-fetch and expects exactly one completion, carrying the first request's address.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_ABS   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_IDX0  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IDX8  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_IDX16 = 3'd3;

  typedef struct packed {
    logic              load;    // capture request inputs, aim read port at PC+1
    logic              step;    // advance read address by one
    logic              capHi;   // keep current read byte as high part
    logic              fin;     // produce results this edge
    logic [MODE_W-1:0] finMode; // form used for the results
  } ea_strobe_t;
endpackage

// File: rtl/ea_control.sv
module ea_control
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output ea_strobe_t        stb,
  output logic              busy,
  output logic              rdEn
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_LAST} ctrl_state_e;

  ctrl_state_e       state, stateNxt;
  logic [MODE_W-1:0] modeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      modeReg <= '0;
    end else begin
      state <= stateNxt;
      if (stb.load) modeReg <= mode;
    end
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          case (mode)
            MODE_ABS, MODE_IDX16: stateNxt = ST_FIRST;
            MODE_IDX8:            stateNxt = ST_LAST;
            default: begin
              stb.fin     = 1'b1;
              stb.finMode = mode;
            end
          endcase
        end
      end
      ST_FIRST: begin
        stb.capHi = 1'b1;
        stb.step  = 1'b1;
        stateNxt  = ST_LAST;
      end
      ST_LAST: begin
        stb.fin     = 1'b1;
        stb.finMode = modeReg;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign rdEn = busy;
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  ea_strobe_t      stb,
  input  logic [DW-1:0]   indexIn,
  input  logic [2*DW-1:0] pcIn,
  input  logic [DW-1:0]   rdData,
  output logic [2*DW-1:0] rdAddr,
  output logic [2*DW-1:0] effAddr,
  output logic [2*DW-1:0] pcNext,
  output logic            done
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] xReg, hiByte, xSrc;
  logic [AW-1:0] pcBase, baseSrc, eaCalc, pcCalc;
  logic [DW:0]   lowSum;

  // on the accept edge the captured copies are not yet loaded
  assign xSrc    = stb.load ? indexIn : xReg;
  assign baseSrc = stb.load ? pcIn : pcBase;
  assign lowSum  = {1'b0, xSrc} + {1'b0, rdData};

  always_comb begin
    eaCalc = '0;
    pcCalc = baseSrc;
    case (stb.finMode)
      MODE_ABS: begin
        eaCalc = {hiByte, rdData};
        pcCalc = baseSrc + AW'(3);
      end
      MODE_IDX0: begin
        eaCalc = {{DW{1'b0}}, xSrc};
        pcCalc = baseSrc + AW'(1);
      end
      MODE_IDX8: begin
        eaCalc = {{(DW-1){1'b0}}, lowSum};
        pcCalc = baseSrc + AW'(2);
      end
      MODE_IDX16: begin
        eaCalc = {hiByte + DW'(lowSum[DW]), lowSum[DW-1:0]};
        pcCalc = baseSrc + AW'(3);
      end
      default: begin
        eaCalc = '0;
        pcCalc = baseSrc;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg    <= '0;
      hiByte  <= '0;
      pcBase  <= '0;
      rdAddr  <= '0;
      effAddr <= '0;
      pcNext  <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.fin;
      if (stb.load) begin
        xReg   <= indexIn;
        pcBase <= pcIn;
        rdAddr <= pcIn + AW'(1);
      end else if (stb.step) begin
        rdAddr <= rdAddr + AW'(1);
      end
      if (stb.capHi) hiByte <= rdData;
      if (stb.fin) begin
        effAddr <= eaCalc;
        pcNext  <= pcCalc;
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     indexReg,
  input  logic [AW-1:0]     pcIn,
  output logic              rdEn,
  output logic [AW-1:0]     rdAddr,
  input  logic [DW-1:0]     rdData,
  output logic [AW-1:0]     effAddr,
  output logic [AW-1:0]     pcNext,
  output logic              done
);
  ea_strobe_t stb;
  logic       ctrlBusy;

  ea_control u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .stb(stb), .busy(ctrlBusy), .rdEn(rdEn)
  );

  ea_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .indexIn(indexReg), .pcIn(pcIn),
    .rdData(rdData), .rdAddr(rdAddr), .effAddr(effAddr), .pcNext(pcNext),
    .done(done)
  );
endmodule

// File: rtl/ea_checker.sv
module ea_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [2:0]  mode,
  input logic [7:0]  indexReg,
  input logic [15:0] pcIn,
  input logic        busy,
  input logic        rdEn,
  input logic [15:0] rdAddr,
  input logic [15:0] effAddr,
  input logic [15:0] pcNext,
  input logic        done
);
  logic [2:0] lastMode;
  logic       accept;
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) lastMode <= 3'd0;
    else if (accept) lastMode <= mode;
  end

  AST_IDX0_RESULT: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 3'd1) |=> (done && effAddr == {8'h00, $past(indexReg)}
                                  && pcNext == $past(pcIn) + 16'd1)); // R2
  AST_IDX8_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && lastMode == 3'd2) |-> (effAddr <= 16'h01FE)); // R3
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> (!rdEn || rdAddr == $past(rdAddr) + 16'd1)); // R6
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rdEn); // R6
  AST_NOP_PC: assert property (@(posedge clk) disable iff (rst)
    (accept && mode[2]) |=> (done && pcNext == $past(pcIn) && effAddr == 16'h0000)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (rdEn || done)); // R7
endmodule

bind eff_addr_unit ea_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .indexReg(indexReg),
  .pcIn(pcIn), .busy(ctrlBusy), .rdEn(rdEn), .rdAddr(rdAddr),
  .effAddr(effAddr), .pcNext(pcNext), .done(done)
);

// File: tb/eff_addr_unit_test.sv
module eff_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  indexReg = 8'h00;
  logic [15:0] pcIn = 16'h0000;
  logic        rdEn;
  logic [15:0] rdAddr, effAddr, pcNext;
  logic [7:0]  rdData;
  logic        done;
  logic [7:0]  memBank [256];

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk; // 125 MHz

  assign rdData = memBank[rdAddr[7:0]];

  eff_addr_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .indexReg(indexReg),
    .pcIn(pcIn), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .effAddr(effAddr), .pcNext(pcNext), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // issue one request and wait for its completion
  task automatic runOp(input logic [2:0] m, input logic [7:0] x, input logic [15:0] pc,
                       input logic [15:0] expEa, input logic [15:0] expPc,
                       input int expLat, input int expReads, input string tag);
    int lat = 0;
    int nReads = 0;
    logic [15:0] rdLog [4];
    @(negedge clk);
    start = 1'b1; mode = m; indexReg = x; pcIn = pc;
    while (lat < 10) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (rdEn) begin
        if (nReads < 4) rdLog[nReads] = rdAddr;
        nReads++;
      end
      if (done) break;
    end
    check(done == 1'b1, {tag, " done"}, done, 1);
    check(lat == expLat, {tag, " latency"}, lat, expLat);
    check(effAddr == expEa, {tag, " effAddr"}, effAddr, expEa);
    check(pcNext == expPc, {tag, " pcNext"}, pcNext, expPc);
    check(nReads == expReads, {tag, " read count"}, nReads, expReads);
    if (expReads >= 1) check(rdLog[0] == pc + 16'd1, {tag, " R6 first read"}, rdLog[0], pc + 16'd1);
    if (expReads >= 2) check(rdLog[1] == pc + 16'd2, {tag, " R6 second read"}, rdLog[1], pc + 16'd2);
    @(negedge clk);
    check(done == 1'b0, {tag, " R7 single done"}, done, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(done == 1'b0, "R8 done", done, 0);
    check(rdEn == 1'b0, "R8 rdEn", rdEn, 0);
    check(effAddr == 16'h0, "R8 effAddr", effAddr, 0);
    check(pcNext == 16'h0, "R8 pcNext", pcNext, 0);
  endtask

  // R7: second start during fetch is ignored
  task automatic testBusyIgnore();
    int dones = 0;
    int firstLat = 0;
    @(negedge clk);
    start = 1'b1; mode = 3'd0; indexReg = 8'h00; pcIn = 16'h1230;
    @(negedge clk);
    mode = 3'd1; indexReg = 8'h11; pcIn = 16'h0000; // start still high while busy
    for (int i = 2; i <= 6; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        dones++;
        if (firstLat == 0) firstLat = i;
        check(effAddr == 16'hABCD, "R7 busy-start effAddr", effAddr, 16'hABCD);
      end
    end
    check(dones == 1, "R7 busy-start done count", dones, 1);
    check(firstLat == 3, "R7 busy-start latency", firstLat, 3);
  endtask

  // R10: start accepted in the done cycle
  task automatic testBackToBack();
    int lat = 0;
    @(negedge clk);
    start = 1'b1; mode = 3'd2; indexReg = 8'h05; pcIn = 16'h7080;
    while (lat < 10) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
    check(effAddr == 16'h000B, "R10 first effAddr", effAddr, 16'h000B);
    check(pcNext == 16'h7082, "R10 first pcNext", pcNext, 16'h7082);
    start = 1'b1; mode = 3'd1; indexReg = 8'h44; pcIn = 16'h9000;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R10 second done", done, 1);
    check(effAddr == 16'h0044, "R10 second effAddr", effAddr, 16'h0044);
    check(pcNext == 16'h9001, "R10 second pcNext", pcNext, 16'h9001);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memBank[i] = 8'h00;
    memBank[8'h31] = 8'hAB; memBank[8'h32] = 8'hCD;
    memBank[8'h41] = 8'h20;
    memBank[8'h51] = 8'hFF;
    memBank[8'h61] = 8'h12; memBank[8'h62] = 8'h80;
    memBank[8'h71] = 8'hFF; memBank[8'h72] = 8'hFF;
    memBank[8'hFF] = 8'h9A; memBank[8'h00] = 8'h3C;
    memBank[8'h81] = 8'h06;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    runOp(3'd0, 8'h00, 16'h1230, 16'hABCD, 16'h1233, 3, 2, "R1 absolute");
    runOp(3'd1, 8'h7E, 16'h4000, 16'h007E, 16'h4001, 1, 0, "R2 index only");
    runOp(3'd2, 8'h10, 16'h2040, 16'h0030, 16'h2042, 2, 1, "R3 index+byte");
    runOp(3'd2, 8'hFF, 16'h0050, 16'h01FE, 16'h0052, 2, 1, "R3 R5 max unsigned");
    runOp(3'd3, 8'h90, 16'h3060, 16'h1310, 16'h3063, 3, 2, "R4 R5 index+word carry");
    runOp(3'd3, 8'h01, 16'h5070, 16'h0000, 16'h5073, 3, 2, "R4 wrap");
    runOp(3'd0, 8'h00, 16'hFFFE, 16'h9A3C, 16'h0001, 3, 2, "R6 pc wrap");
    runOp(3'd5, 8'h22, 16'h6666, 16'h0000, 16'h6666, 1, 0, "R9 no-op");
    runOp(3'd7, 8'h22, 16'h0101, 16'h0000, 16'h0101, 1, 0, "R9 no-op 7");
    testBusyIgnore();
    testBackToBack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule